// File: doc/BRIEF.md
# Codec Command Ring Fetch Engine

This block feeds codec commands to a serial codec link. Software keeps a circular list of 32-bit command words in host memory and advances a write pointer. The engine owns the matching read pointer. It reads one word at a time from memory, splits it into codec address, node number and payload, and presents it to the link dispatcher with a valid strobe. Each word is held until the dispatcher acknowledges it, and only then does the read pointer move on.

A single immediate command word can also be posted with a busy flag. When that flag is set it is served ahead of any ring entry. The engine does not poll. It looks for work only after a kick pulse, which the surrounding register file raises when software writes the write pointer, the control bit or the immediate status, or clears the response interrupt flag. It then keeps going until it finds no work it may do. The ring may be stopped, it may be empty, or the count of received responses may have reached its programmed limit. At that point the engine goes quiet until the next kick.

A command word with the indirect addressing bit set is discarded. So is a word aimed at a codec slot that is not present. A discarded ring word still consumes its ring slot, and a discarded immediate word still completes.

Top module: `command_ring_fetch`

## Requirements
- R1: When `imm_busy` is high and the engine evaluates work, the immediate word `imm_verb` is dispatched before any ring fetch. Completion is a one-cycle `imm_done` pulse. This comes after `verb_ack` if the word was sent, or at once if it was discarded. The engine ignores `imm_busy` during the cycle in which `imm_done` is high, and the owner of the flag clears it in that cycle.
- R2: No ring read is issued while `run_en` is low.
- R3: The ring is empty, and no read is issued, when `rd_ptr` equals `wr_ptr` (8 bits).
- R4: No ring read is issued while `resp_count` equals `resp_limit`.
- R5: A ring read requests address {ring_base_hi, ring_base_lo} + 4 × ((rd_ptr + 1) mod 256). `rd_req` and `rd_addr` hold steady until `rd_valid`.
- R6: A dispatched word is split into `verb_cad` = bits 31:28, `verb_nid` = bits 26:20 and `verb_payload` = bits 19:0. `verb_valid` and the fields hold steady until `verb_ack`.
- R7: A word with bit 27 set is discarded. A word whose bits 31:28 select a zero bit of `codec_present` is discarded. Neither raises `verb_valid`.
- R8: `rd_ptr` resets to 0. It advances by exactly one, modulo 256, either when a ring word is acknowledged or when a fetched ring word is discarded, and it never moves otherwise.
- R9: Work is evaluated only after a `kick` pulse. A change of `wr_ptr` without a kick starts no read. After a kick the engine drains all permitted entries without further kicks.
- R10: After reset, `rd_req`, `verb_valid` and `imm_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base_lo | input | 32 | Ring base address, low half |
| ring_base_hi | input | 32 | Ring base address, high half |
| wr_ptr | input | 8 | Software write pointer |
| run_en | input | 1 | Ring run control |
| kick | input | 1 | Re-evaluate work (pulse) |
| imm_verb | input | 32 | Immediate command word |
| imm_busy | input | 1 | Immediate command pending |
| imm_done | output | 1 | Immediate command completed (pulse) |
| resp_count | input | 8 | Responses received so far |
| resp_limit | input | 8 | Programmed response threshold |
| codec_present | input | 16 | One bit per codec address slot |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 64 | Memory read byte address |
| rd_valid | input | 1 | Memory read data valid |
| rd_data | input | 32 | Memory read data |
| rd_ptr | output | 8 | Hardware read pointer |
| verb_valid | output | 1 | Decoded command valid |
| verb_cad | output | 4 | Codec address |
| verb_nid | output | 7 | Node number |
| verb_payload | output | 20 | Command payload |
| verb_ack | input | 1 | Dispatcher accepted the command |

## Verification
The hardest situation to reach from the ports is one where several conditions coincide. The read pointer crosses from 255 to 0 and discarded words sit in the same stretch of ring. A fresh base address also changes the wrapped address arithmetic. The bench reaches it with about a dozen random rounds. Each round sets a random base, a random present mask, and random words of which roughly one in five carry the indirect bit, then advances the write pointer by 10 to 60 slots, so the pointer wraps more than once. Directed cases cover the rest: a pending immediate word that must jump ahead of queued ring entries, and a kick that arrives while the ring is stopped, empty or stalled.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  localparam int CAD_W   = 4;
  localparam int NID_W   = 7;
  localparam int PAY_W   = 20;
  localparam int VERB_W  = CAD_W + 1 + NID_W + PAY_W;
  localparam int N_CODEC = 1 << CAD_W;

  typedef struct packed {
    logic [CAD_W-1:0] cad;
    logic             indirect;
    logic [NID_W-1:0] nid;
    logic [PAY_W-1:0] payload;
  } verb_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SEND  = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/cmdring_verb_decode.sv
module cmdring_verb_decode
  import cmdring_pkg::*;
(
  input  logic [VERB_W-1:0]  raw,
  input  logic [N_CODEC-1:0] present,
  output verb_t              fields,
  output logic               accept
);
  always_comb begin
    fields = verb_t'(raw);
    accept = !fields.indirect && present[fields.cad];
  end
endmodule

// File: rtl/cmdring_ptr_unit.sv
module cmdring_ptr_unit #(
  parameter int PTR_W  = 8,
  parameter int BASE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance,
  input  logic [PTR_W-1:0]    wr_ptr,
  input  logic [BASE_W-1:0]   base_lo,
  input  logic [BASE_W-1:0]   base_hi,
  output logic [PTR_W-1:0]    rd_ptr,
  output logic                empty,
  output logic [2*BASE_W-1:0] fetch_addr
);
  localparam int ADDR_W = 2 * BASE_W;

  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_next;

  always_comb begin
    ptr_next   = ptr_q + 1'b1;
    ptr_d      = advance ? ptr_next : ptr_q;
    empty      = (ptr_q == wr_ptr);
    fetch_addr = {base_hi, base_lo} +
                 {{(ADDR_W-PTR_W-2){1'b0}}, ptr_next, 2'b00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (advance) ptr_q <= ptr_d;
  end

  assign rd_ptr = ptr_q;

  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ptr_q == $past(ptr_q)) || (ptr_q == PTR_W'($past(ptr_q) + 1'b1)))
    else $error("read pointer moved by more than one");
endmodule

// File: rtl/command_ring_fetch.sv
module command_ring_fetch
  import cmdring_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int BASE_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BASE_W-1:0]   ring_base_lo,
  input  logic [BASE_W-1:0]   ring_base_hi,
  input  logic [PTR_W-1:0]    wr_ptr,
  input  logic                run_en,
  input  logic                kick,
  input  logic [VERB_W-1:0]   imm_verb,
  input  logic                imm_busy,
  output logic                imm_done,
  input  logic [CNT_W-1:0]    resp_count,
  input  logic [CNT_W-1:0]    resp_limit,
  input  logic [N_CODEC-1:0]  codec_present,
  output logic                rd_req,
  output logic [2*BASE_W-1:0] rd_addr,
  input  logic                rd_valid,
  input  logic [VERB_W-1:0]   rd_data,
  output logic [PTR_W-1:0]    rd_ptr,
  output logic                verb_valid,
  output logic [CAD_W-1:0]    verb_cad,
  output logic [NID_W-1:0]    verb_nid,
  output logic [PAY_W-1:0]    verb_payload,
  input  logic                verb_ack
);
  fetch_state_e      state_q, state_d;
  logic              armed_q, armed_d;
  logic              from_imm_q, from_imm_d;
  logic              done_q, done_d;
  logic [VERB_W-1:0] verb_q, verb_d;
  logic              verb_en;
  logic              advance, empty, stall, imm_seen;
  logic [VERB_W-1:0] cand;
  verb_t             cand_f, held_f;
  logic              cand_ok;

  cmdring_ptr_unit #(.PTR_W(PTR_W), .BASE_W(BASE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .advance(advance), .wr_ptr(wr_ptr),
    .base_lo(ring_base_lo), .base_hi(ring_base_hi),
    .rd_ptr(rd_ptr), .empty(empty), .fetch_addr(rd_addr)
  );

  assign cand = (state_q == ST_FETCH) ? rd_data : imm_verb;

  cmdring_verb_decode u_dec (
    .raw(cand), .present(codec_present), .fields(cand_f), .accept(cand_ok)
  );

  always_comb begin
    stall      = (resp_count == resp_limit);
    imm_seen   = imm_busy && !done_q;
    state_d    = state_q;
    armed_d    = armed_q | kick;
    from_imm_d = from_imm_q;
    done_d     = 1'b0;
    verb_d     = verb_q;
    verb_en    = 1'b0;
    advance    = 1'b0;
    rd_req     = 1'b0;
    verb_valid = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (armed_q) begin
          if (imm_seen) begin
            if (cand_ok) begin
              verb_d     = imm_verb;
              verb_en    = 1'b1;
              from_imm_d = 1'b1;
              state_d    = ST_SEND;
            end else begin
              done_d = 1'b1;
            end
          end else if (!run_en || empty || stall) begin
            armed_d = kick;
          end else begin
            state_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        rd_req = 1'b1;
        if (rd_valid) begin
          if (cand_ok) begin
            verb_d     = rd_data;
            verb_en    = 1'b1;
            from_imm_d = 1'b0;
            state_d    = ST_SEND;
          end else begin
            advance = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_SEND: begin
        verb_valid = 1'b1;
        if (verb_ack) begin
          if (from_imm_q) done_d = 1'b1;
          else advance = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      armed_q    <= 1'b0;
      from_imm_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      armed_q    <= armed_d;
      from_imm_q <= from_imm_d;
      done_q     <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) verb_q <= '0;
    else if (verb_en) verb_q <= verb_d;
  end

  assign held_f       = verb_t'(verb_q);
  assign verb_cad     = held_f.cad;
  assign verb_nid     = held_f.nid;
  assign verb_payload = held_f.payload;
  assign imm_done     = done_q;

  p_imm_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> !$past(imm_busy && !done_q))
    else $error("ring read started while immediate pending");
  p_imm_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    imm_done |=> !imm_done)
    else $error("immediate completion longer than one cycle");
  p_run_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> $past(run_en))
    else $error("read issued while stopped");
  p_empty_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> $past(rd_ptr != wr_ptr))
    else $error("read issued on empty ring");
  p_stall_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> $past(resp_count != resp_limit))
    else $error("read issued while stalled");
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr))
    else $error("read request dropped before data");
  p_verb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    verb_valid && !verb_ack |=> verb_valid && $stable(verb_q))
    else $error("command changed before acknowledge");
  p_no_bad_verb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    verb_valid |-> !held_f.indirect && codec_present[verb_cad])
    else $error("discardable command dispatched");
endmodule

// File: tb/tb_command_ring_fetch.sv
module tb_command_ring_fetch;
  logic        clk, rst_n;
  logic [31:0] ring_base_lo, ring_base_hi;
  logic [7:0]  wr_ptr;
  logic        run_en, kick;
  logic [31:0] imm_verb;
  logic        imm_busy, imm_done;
  logic [7:0]  resp_count, resp_limit;
  logic [15:0] codec_present;
  logic        rd_req, rd_valid;
  logic [63:0] rd_addr;
  logic [31:0] rd_data;
  logic [7:0]  rd_ptr;
  logic        verb_valid, verb_ack;
  logic [3:0]  verb_cad;
  logic [6:0]  verb_nid;
  logic [19:0] verb_payload;

  command_ring_fetch dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] ring_mem [256];
  logic [31:0] vlog [4096];
  int nlog = 0, nfetch = 0, nimm = 0;
  logic [7:0] model_rp = 8'd0;
  logic [31:0] expv [512];
  int nexp;

  function automatic logic [31:0] mk(input logic [3:0] c, input logic ind,
                                     input logic [6:0] n, input logic [19:0] p);
    return {c, ind, n, p};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // memory responder: checks R5 addresses against bench pointer model
  initial begin
    int dly = 0;
    rd_valid = 0; rd_data = '0;
    forever begin
      @(negedge clk);
      if (rd_valid) rd_valid = 0;
      else if (rd_req) begin
        if (dly > 0) dly--;
        else begin
          logic [63:0] ea;
          logic [7:0]  idx;
          idx = model_rp + 8'd1;
          ea  = {ring_base_hi, ring_base_lo} + {54'd0, idx, 2'b00};
          chk(rd_addr == ea, "R5 fetch address", rd_addr, ea);
          rd_data  = ring_mem[idx];
          rd_valid = 1;
          model_rp = idx;
          nfetch++;
          dly = $urandom % 3;
        end
      end
    end
  end

  // dispatch sink: records commands (R6)
  initial begin
    int dly = 0;
    verb_ack = 0;
    forever begin
      @(negedge clk);
      if (verb_ack) verb_ack = 0;
      else if (verb_valid) begin
        if (dly > 0) dly--;
        else begin
          vlog[nlog] = {verb_cad, 1'b0, verb_nid, verb_payload};
          nlog++;
          verb_ack = 1;
          dly = $urandom % 3;
        end
      end
    end
  end

  // owner of the immediate busy flag (R1)
  initial begin
    forever begin
      @(negedge clk);
      if (imm_done) begin
        imm_busy = 0;
        nimm++;
      end
    end
  end

  task automatic do_kick();
    @(negedge clk) kick = 1;
    @(negedge clk) kick = 0;
  endtask

  task automatic drain();
    int t = 0;
    while (!(rd_ptr == wr_ptr && !verb_valid && !rd_req && !imm_busy) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic build_exp(input logic [7:0] from, input logic [7:0] to);
    logic [7:0] p;
    p = from;
    nexp = 0;
    while (p != to) begin
      p = p + 8'd1;
      if (!ring_mem[p][27] && codec_present[ring_mem[p][31:28]]) begin
        expv[nexp] = ring_mem[p];
        nexp++;
      end
    end
  endtask

  task automatic cmp_log(input int base, input string tag);
    int bad = -1;
    chk(nlog - base == nexp, {tag, " count"}, 64'(nlog - base), 64'(nexp));
    for (int i = 0; i < nexp && i < nlog - base; i++)
      if (bad < 0 && vlog[base + i] != expv[i]) bad = i;
    if (bad >= 0) chk(0, {tag, " content"}, vlog[base + bad], expv[bad]);
    else chk(1, {tag, " content"}, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lb, fb;
    logic [7:0] start;
    bit wrapped = 0;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 256; i++) ring_mem[i] = '0;
    rst_n = 0; kick = 0; run_en = 0; wr_ptr = 0; imm_busy = 0; imm_verb = '0;
    ring_base_lo = 32'h0000_1000; ring_base_hi = 32'h0000_0001;
    resp_count = 0; resp_limit = 8'd200; codec_present = 16'h000F;
    repeat (3) @(negedge clk);
    chk(!rd_req && !verb_valid && !imm_done, "R10 outputs in reset",
        {rd_req, verb_valid, imm_done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(rd_ptr == 0, "R10 read pointer after reset", rd_ptr, 0);

    // directed: decode and drops
    ring_mem[1] = mk(4'd1, 0, 7'h25, 20'h12345);
    ring_mem[2] = mk(4'd2, 1, 7'h11, 20'h00001);
    ring_mem[3] = mk(4'd9, 0, 7'h02, 20'h0abcd);
    ring_mem[4] = mk(4'd3, 0, 7'h7f, 20'hfffff);
    wr_ptr = 4; run_en = 1;
    lb = nlog;
    do_kick(); drain();
    build_exp(0, 4);
    chk(nexp == 2, "R7 model sanity", nexp, 2);
    cmp_log(lb, "R6 R7 directed decode");
    chk(rd_ptr == 4, "R8 pointer after drops", rd_ptr, 4);
    chk(nfetch == 4, "R5 fetch count", nfetch, 4);

    // stopped ring
    for (int i = 5; i <= 16; i++) ring_mem[i] = mk(4'(i % 4), 0, 7'(i), 20'(i * 3));
    run_en = 0; wr_ptr = 8; fb = nfetch;
    do_kick(); repeat (30) @(negedge clk);
    chk(nfetch == fb && rd_ptr == 4, "R2 no fetch while stopped", rd_ptr, 4);

    // run set without kick
    run_en = 1;
    repeat (30) @(negedge clk);
    chk(nfetch == fb, "R9 no fetch without kick", nfetch, fb);
    lb = nlog;
    do_kick(); drain();
    build_exp(4, 8);
    cmp_log(lb, "R9 drain after kick");
    chk(rd_ptr == 8, "R9 pointer after drain", rd_ptr, 8);

    // stall on response count
    resp_count = 8'd3; resp_limit = 8'd3; wr_ptr = 12; fb = nfetch;
    do_kick(); repeat (30) @(negedge clk);
    chk(nfetch == fb && rd_ptr == 8, "R4 stall at threshold", rd_ptr, 8);
    resp_count = 8'd0;
    do_kick(); drain();
    chk(rd_ptr == 12, "R4 resumes after threshold change", rd_ptr, 12);

    // empty ring
    fb = nfetch;
    do_kick(); repeat (30) @(negedge clk);
    chk(nfetch == fb, "R3 empty ring no fetch", nfetch, fb);

    // immediate priority over queued ring work
    imm_verb = mk(4'd2, 0, 7'h33, 20'h5a5a5); imm_busy = 1; wr_ptr = 16;
    lb = nlog; fb = nimm;
    do_kick(); drain();
    chk(nlog > lb && vlog[lb] == imm_verb, "R1 immediate sent first", vlog[lb], imm_verb);
    chk(nimm == fb + 1, "R1 immediate completion", nimm, fb + 1);
    build_exp(12, 16);
    expv[nexp] = '0;
    for (int i = nexp; i > 0; i--) expv[i] = expv[i-1];
    expv[0] = imm_verb; nexp++;
    cmp_log(lb, "R1 immediate then ring");

    // discarded immediate
    run_en = 0;
    imm_verb = mk(4'd1, 1, 7'h01, 20'h1); imm_busy = 1;
    lb = nlog; fb = nimm;
    do_kick(); drain();
    chk(nimm == fb + 1 && nlog == lb, "R7 indirect immediate discarded", nlog - lb, 0);
    imm_verb = mk(4'd12, 0, 7'h01, 20'h1); imm_busy = 1; fb = nimm;
    do_kick(); drain();
    chk(nimm == fb + 1 && nlog == lb, "R7 absent-codec immediate discarded", nlog - lb, 0);
    run_en = 1;

    // random rounds, wrapping the pointer
    for (int r = 0; r < 14; r++) begin
      logic [7:0] step, p;
      start = rd_ptr;
      step = 8'(10 + $urandom % 51);
      ring_base_lo = {$urandom, 2'b00};
      ring_base_hi = $urandom;
      codec_present = 16'($urandom) | 16'h0001;
      p = start;
      for (int k = 0; k < step; k++) begin
        logic [31:0] v;
        p = p + 8'd1;
        v = $urandom;
        v[27] = (($urandom % 5) == 0);
        ring_mem[p] = v;
      end
      wr_ptr = start + step;
      if (wr_ptr < start) wrapped = 1;
      lb = nlog;
      do_kick(); drain();
      build_exp(start, wr_ptr);
      cmp_log(lb, "R6 R7 random round");
      chk(rd_ptr == wr_ptr, "R8 random round pointer", rd_ptr, wr_ptr);
    end
    chk(wrapped, "R8 pointer wrapped past 255", wrapped, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule